// File: doc/BRIEF.md
# Two-Phase Mailbox Doorbell

This block is the device-side doorbell register through which a host posts a command mailbox by its physical address. The mailbox is 16-byte aligned, so the host sends the address as two 32-bit writes to a single register. One write has the phase flag (bit 1) set and carries the upper address part. The other has the flag clear and carries the lower part. After each write the register reports busy on its read-only ready bit. The high phase clears busy one cycle later. The low phase stays busy until the internal command processor reports that the completion entry has been written.

Once both halves have arrived, the block raises a fetch request toward the command processor. The request carries the assembled mailbox address and the address of the completion entry. The mailbox holds a 256-byte work request followed by a 16-byte completion entry, so the completion entry sits 256 bytes above the mailbox start. Writes that break the protocol are dropped, and they set a sticky error flag that the host can read.

The controller is a five-state machine. IDLE means ready, with no high part held. HI_ACK is a one-cycle busy acknowledge of a high write. HI_HELD means ready, with the high part stored. FETCH drives the request until the processor accepts it. WAIT_CPL is busy until the completion is reported. The transitions are:

- IDLE to HI_ACK on a high write.
- IDLE to IDLE on a low write, which is an orphan and sets the error flag.
- HI_ACK to HI_HELD unconditionally.
- HI_HELD to HI_ACK on a high write, which replaces the stored high part.
- HI_HELD to FETCH on a low write.
- FETCH to WAIT_CPL on a request accept.
- WAIT_CPL to IDLE on completion.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, reg_rdata bit 0 (ready) is 1, bit 1 (high part held) is 0, bit 2 (sticky error) is 0, and fetch_req is 0.
- R2: A write with wdata bit 1 = 1 while ready stores wdata[31:2] as mailbox address bits 63:34. Ready then reads 0 for exactly one cycle and returns to 1, with read bit 1 = 1.
- R3: A write with wdata bit 1 = 0 while a high part is held and ready is 1 stores wdata[31:2] as address bits 33:4. From the next cycle, ready reads 0 and fetch_req is 1 with fetch_addr = {high part, low part, 4'b0000}.
- R4: While fetch_req is 1, cpl_addr equals fetch_addr + 256.
- R5: fetch_req and fetch_addr hold steady until fetch_ack is sampled high with fetch_req. fetch_req is 0 from the following cycle.
- R6: After the request is accepted, ready stays 0 until cpl_done is sampled high. Ready is 1 and read bit 1 is 0 from the following cycle.
- R7: A write with bit 1 = 0 while no high part is held starts no fetch, leaves ready at 1, and sets the sticky error bit.
- R8: A write that arrives while ready is 0 is ignored: the stored address and the state are unchanged. It sets the sticky error bit.
- R9: The sticky error bit stays 1 until reset, including across later correct transactions.
- R10: A second high write while a high part is held replaces the stored high part. Bit 0 of any written value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data: bits 31:2 address field, bit 1 phase flag |
| reg_rdata | output | 32 | Read data: bit 0 ready, bit 1 high part held, bit 2 sticky error |
| fetch_req | output | 1 | Request to the command processor to fetch the mailbox |
| fetch_addr | output | 64 | Assembled mailbox address |
| cpl_addr | output | 64 | Completion entry address (mailbox + 256) |
| fetch_ack | input | 1 | Processor accepted the request |
| cpl_done | input | 1 | Processor wrote the completion entry |

## Verification
A state machine stuck in or skipping a state appears at the ports within one cycle of the offending write. A skipped HI_ACK shows as ready failing to drop for one cycle. A premature FETCH shows as fetch_req rising on an orphan low write. A lost WAIT_CPL shows as ready returning before cpl_done. Wrong address packing or a busy write that leaks into the address registers shows on fetch_addr in the first cycle of the request. The sticky error bit is read back directly after each protocol violation and again after a later clean transaction.

// File: rtl/mbdb_pkg.sv
package mbdb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI_ACK,
        ST_HI_HELD,
        ST_FETCH,
        ST_WAIT_CPL
    } mbdb_state_e;

    localparam int RDY_BIT = 0;
    localparam int HI_BIT  = 1;
    localparam int ERR_BIT = 2;

endpackage

// File: rtl/mbdb_fsm.sv
module mbdb_fsm
    import mbdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_hi,
    input  logic fetch_ack,
    input  logic cpl_done,
    output logic load_hi,
    output logic load_lo,
    output logic ready,
    output logic hi_held,
    output logic proto_err,
    output logic fetch_req
);

    mbdb_state_e state_q, state_d;
    logic        err_q;
    logic        err_set;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (wr_en && wr_hi)      state_d = ST_HI_ACK;
            ST_HI_ACK:                            state_d = ST_HI_HELD;
            ST_HI_HELD:  if (wr_en)               state_d = wr_hi ? ST_HI_ACK : ST_FETCH;
            ST_FETCH:    if (fetch_ack)           state_d = ST_WAIT_CPL;
            ST_WAIT_CPL: if (cpl_done)            state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        hi_held   = 1'b0;
        fetch_req = 1'b0;
        load_hi   = 1'b0;
        load_lo   = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready   = 1'b1;
                load_hi = wr_en && wr_hi;
                err_set = wr_en && !wr_hi;
            end
            ST_HI_ACK: begin
                err_set = wr_en;
            end
            ST_HI_HELD: begin
                ready   = 1'b1;
                hi_held = 1'b1;
                load_hi = wr_en && wr_hi;
                load_lo = wr_en && !wr_hi;
            end
            ST_FETCH: begin
                fetch_req = 1'b1;
                err_set   = wr_en;
            end
            ST_WAIT_CPL: begin
                err_set = wr_en;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    assign proto_err = err_q;

    AST_HI_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI_ACK) |=> (state_q == ST_HI_HELD)); // R2
    AST_ORPHAN_LOW_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !hi_held && wr_en && !wr_hi) |=> (!fetch_req && ready && proto_err)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R9
    AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && wr_en) |=> proto_err); // R8

endmodule

// File: rtl/mbdb_addr.sv
module mbdb_addr #(
    parameter int REG_W      = 32,
    parameter int ALIGN_BITS = 4,
    parameter int WRB_BYTES  = 256,
    localparam int FIELD_W   = REG_W - 2,
    localparam int ADDR_W    = 2 * FIELD_W + ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [REG_W-1:0]  wdata,
    output logic [ADDR_W-1:0] mbox_addr,
    output logic [ADDR_W-1:0] cpl_addr
);

    logic [FIELD_W-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (load_hi) hi_q <= wdata[REG_W-1:2];
            if (load_lo) lo_q <= wdata[REG_W-1:2];
        end
    end

    assign mbox_addr = {hi_q, lo_q, {ALIGN_BITS{1'b0}}};
    assign cpl_addr  = mbox_addr + ADDR_W'(WRB_BYTES);

endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
    import mbdb_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int ALIGN_BITS = 4,
    parameter int WRB_BYTES  = 256,
    localparam int ADDR_W    = 2 * (REG_W - 2) + ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] cpl_addr,
    input  logic              fetch_ack,
    input  logic              cpl_done
);

    logic load_hi, load_lo, ready, hi_held, proto_err;

    mbdb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_hi     (reg_wdata[HI_BIT]),
        .fetch_ack (fetch_ack),
        .cpl_done  (cpl_done),
        .load_hi   (load_hi),
        .load_lo   (load_lo),
        .ready     (ready),
        .hi_held   (hi_held),
        .proto_err (proto_err),
        .fetch_req (fetch_req)
    );

    mbdb_addr #(
        .REG_W      (REG_W),
        .ALIGN_BITS (ALIGN_BITS),
        .WRB_BYTES  (WRB_BYTES)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_hi   (load_hi),
        .load_lo   (load_lo),
        .wdata     (reg_wdata),
        .mbox_addr (fetch_addr),
        .cpl_addr  (cpl_addr)
    );

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[RDY_BIT] = ready;
        reg_rdata[HI_BIT]  = hi_held;
        reg_rdata[ERR_BIT] = proto_err;
    end

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr))); // R5
    AST_BUSY_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !ready); // R6
    AST_BUSY_WRITE_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && reg_wr) |=> $stable(fetch_addr)); // R8
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack) |=> (!fetch_req && !ready)); // R5

endmodule

// File: tb/mbox_doorbell_test.sv
module mbox_doorbell_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_req;
    logic [63:0] fetch_addr;
    logic [63:0] cpl_addr;
    logic        fetch_ack = 1'b0;
    logic        cpl_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mbox_doorbell uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .cpl_addr   (cpl_addr),
        .fetch_ack  (fetch_ack),
        .cpl_done   (cpl_done)
    );

    function automatic logic [63:0] exp_addr(logic [29:0] hi, logic [29:0] lo);
        return {hi, lo, 4'b0000};
    endfunction

    function automatic logic [31:0] hi_word(logic [29:0] hi, logic b0);
        return {hi, 1'b1, b0};
    endfunction

    function automatic logic [31:0] lo_word(logic [29:0] lo, logic b0);
        return {lo, 1'b0, b0};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; fetch_ack = 1'b0; cpl_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_fetch(logic [63:0] ea, int ackwait, int cplwait);
        repeat (ackwait) begin
            @(negedge clk);
            check("R5 req held", fetch_req, 1);
            check("R5 addr held", fetch_addr, ea);
        end
        @(negedge clk); fetch_ack = 1'b1;
        @(negedge clk); fetch_ack = 1'b0;
        check("R5 req drops", fetch_req, 0);
        check("R6 busy after accept", reg_rdata[0], 0);
        repeat (cplwait) begin
            @(negedge clk);
            check("R6 busy until cpl", reg_rdata[0], 0);
        end
        @(negedge clk); cpl_done = 1'b1;
        @(negedge clk); cpl_done = 1'b0;
        check("R6 ready after cpl", reg_rdata[0], 1);
        check("R6 high cleared", reg_rdata[1], 0);
    endtask

    task automatic run_txn(logic [29:0] hi, logic [29:0] lo, logic b0, int ackwait, int cplwait);
        logic [63:0] ea;
        ea = exp_addr(hi, lo);
        do_write(hi_word(hi, b0));
        check("R2 busy one cycle", reg_rdata[0], 0);
        @(negedge clk);
        check("R2 ready back", reg_rdata[0], 1);
        check("R2 high held", reg_rdata[1], 1);
        do_write(lo_word(lo, ~b0));
        check("R3 busy", reg_rdata[0], 0);
        check("R3 fetch_req", fetch_req, 1);
        check("R3 fetch_addr", fetch_addr, ea);
        check("R4 cpl_addr", cpl_addr, ea + 64'd256);
        finish_fetch(ea, ackwait, cplwait);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [29:0] h1, h2, lo;
        logic [63:0] ea;
        void'($urandom(32'h5eed_1234));

        do_reset();
        check("R1 ready", reg_rdata[0], 1);
        check("R1 high held", reg_rdata[1], 0);
        check("R1 error", reg_rdata[2], 0);
        check("R1 fetch_req", fetch_req, 0);

        // Directed: extreme address patterns
        run_txn(30'h3fff_ffff, 30'h3fff_ffff, 1'b1, 0, 0);
        run_txn(30'h0, 30'h0, 1'b0, 2, 3);
        run_txn(30'h2aaa_aaaa, 30'h1555_5555, 1'b1, 1, 1);
        check("R9 no error on clean use", reg_rdata[2], 0);

        // R10: second high write replaces first
        h1 = 30'h0123_4567; h2 = 30'h3765_4321; lo = 30'h0abc_def0;
        do_write(hi_word(h1, 1'b0));
        @(negedge clk);
        do_write(hi_word(h2, 1'b1));
        @(negedge clk);
        do_write(lo_word(lo, 1'b1));
        check("R10 replaced high", fetch_addr, exp_addr(h2, lo));
        check("R10 no error", reg_rdata[2], 0);
        finish_fetch(exp_addr(h2, lo), 0, 0);

        // R7: orphan low write
        do_reset();
        do_write(lo_word(30'h1234_5678, 1'b0));
        check("R7 error set", reg_rdata[2], 1);
        check("R7 no fetch", fetch_req, 0);
        check("R7 ready stays", reg_rdata[0], 1);
        @(negedge clk);
        check("R7 still no fetch", fetch_req, 0);
        check("R7 no high held", reg_rdata[1], 0);

        // R8: write during busy high ack is ignored
        do_reset();
        h1 = 30'h1111_2222; h2 = 30'h3333_0000; lo = 30'h0555_6666;
        do_write(hi_word(h1, 1'b0));
        reg_wr = 1'b1; reg_wdata = hi_word(h2, 1'b0);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8 error set", reg_rdata[2], 1);
        check("R8 state kept", reg_rdata[1:0], 2'b11);
        do_write(lo_word(lo, 1'b0));
        ea = exp_addr(h1, lo);
        check("R8 high not replaced", fetch_addr, ea);
        // busy write during fetch: ignored
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = lo_word(30'h3fff_0000, 1'b0);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8 addr unchanged in fetch", fetch_addr, ea);
        check("R8 req still", fetch_req, 1);
        finish_fetch(ea, 0, 1);
        @(negedge clk);
        check("R8 no second fetch", fetch_req, 0);
        check("R9 error still set", reg_rdata[2], 1);
        run_txn(30'h0fed_cba9, 30'h0123_0fed, 1'b0, 1, 0);
        check("R9 error after clean txn", reg_rdata[2], 1);

        // Random transactions
        do_reset();
        for (int i = 0; i < 40; i++) begin
            run_txn(30'($urandom), 30'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 5));
        end
        check("R9 no error after random clean", reg_rdata[2], 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule